// File: doc/BRIEF.md
# Memory-Type-Aware Store Write Buffer

This block holds core stores between a store port and an external write port. A store completes on the core side in the cycle it is accepted, and it reaches the external port later. Every store carries a two-bit memory-type attribute, and that attribute decides how the store is treated. Relaxed (normal) stores may coalesce byte-wise into a queued entry for the same aligned word. Device and strongly-ordered stores always take an entry of their own, and no later write may be moved ahead of them.

Entries leave the buffer oldest first over a valid/ready write port. A relaxed store that joins an existing entry leaves with that entry. This is the only way a write can pass another write.

A barrier request stops new stores and waits until the buffer is empty. The block then returns a one-cycle acknowledge, so software can rely on every earlier write having been taken downstream.

Top module: `wbuf_top`

## Requirements
- R1: A store is accepted in a cycle where `s_valid` and `s_ready` are both high. From the next cycle on it is held in the buffer and later appears on the write port. `m_addr` carries the store's address with the low two bits cleared.
- R2: The type codes are: 2'b00 relaxed, 2'b01 device, 2'b10 strongly-ordered. Code 2'b11 is handled like strongly-ordered. `m_type` reports the stored code unchanged.
- R3: A relaxed store to the same aligned word as a queued relaxed entry merges into that entry. Bytes whose strobe is set replace the old bytes, and the entry's strobe mask becomes the OR of both masks. If several queued entries qualify, the youngest one is chosen.
- R4: No store merges into the entry currently presented on the write port, which is the oldest entry.
- R5: A device or strongly-ordered store never merges and is never merged into. It always occupies a new entry.
- R6: Entries leave in allocation order, oldest first. A merged store leaves with the entry it joined, so a relaxed write may overtake younger relaxed entries for other words.
- R7: A relaxed store never merges into an entry that is older than a queued device or strongly-ordered entry. No write therefore leaves ahead of an older device or strongly-ordered write.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr`, `m_data`, `m_strb` and `m_type` hold their values into the next cycle.
- R9: With all 4 entries occupied, `s_ready` is low unless the presented store can merge. If it can merge, `s_ready` is high.
- R10: `bar_ack` is high only when the buffer is empty. It lasts exactly one cycle. It comes no earlier than the cycle after the request is sampled: on an empty buffer, exactly that cycle; otherwise, the cycle after the last entry is accepted.
- R11: From the cycle after a barrier request is sampled through its acknowledge cycle, `s_ready` is low. A request made while a barrier is already pending joins that barrier.
- R12: After reset the buffer is empty: `m_valid` is 0, `bar_ack` is 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_valid | input | 1 | Store request valid |
| s_ready | output | 1 | Store accepted when high with s_valid |
| s_addr | input | AW | Store byte address |
| s_data | input | DW | Store data |
| s_strb | input | DW/8 | Store byte strobes |
| s_type | input | 2 | Memory-type code of the store |
| m_valid | output | 1 | Write port valid |
| m_ready | input | 1 | Write accepted downstream |
| m_addr | output | AW | Word-aligned write address |
| m_data | output | DW | Write data |
| m_strb | output | DW/8 | Write byte strobes |
| m_type | output | 2 | Memory-type code of the write |
| bar_req | input | 1 | Barrier request |
| bar_ack | output | 1 | One-cycle barrier completion |

## Verification
The hardest condition to reach is a merge candidate that must be refused. This happens in two cases: the matching entry is the one being presented, or a younger device or strongly-ordered entry sits behind it. Both need several entries held in the buffer at the same time. The bench reaches them by keeping `m_ready` low while it loads a filler store into the head entry, then a sequence of stores to chosen words. It then releases the port and compares the drained writes against sequences it computes itself. A sweep over every pair of type codes and non-zero strobe patterns covers each merge decision.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam logic [1:0] MT_RELAXED = 2'b00;
  localparam logic [1:0] MT_DEVICE  = 2'b01;
  localparam logic [1:0] MT_STRICT  = 2'b10;

  // Only the relaxed code may merge or be merged into; 2'b11 counts as strict.
  function automatic logic is_relaxed(input logic [1:0] t);
    return t == MT_RELAXED;
  endfunction
endpackage

// File: rtl/wbuf_rst_sync.sv
module wbuf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/wbuf_merge_find.sv
module wbuf_merge_find #(
  parameter int DEPTH = 4,
  parameter int WAW   = 30,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] rel,
  input  logic [WAW-1:0]   wa [DEPTH],
  input  logic [WAW-1:0]   in_wa,
  output logic             hit,
  output logic [IW-1:0]    idx
);
  logic [DEPTH-1:0] same_word;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign same_word[g] = vld[g] && (wa[g] == in_wa);
  end

  // Scan youngest to oldest; slot 0 is on the port and never a target.
  // A strict entry seen on the way blocks every older candidate.
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    hit     = 1'b0;
    idx     = '0;
    for (int j = DEPTH - 1; j >= 1; j--) begin
      if (!hit && !blocked && same_word[j] && rel[j]) begin
        hit = 1'b1;
        idx = IW'(j);
      end
      if (vld[j] && !rel[j]) blocked = 1'b1;
    end
  end
endmodule

// File: rtl/wbuf_byte_merge.sv
module wbuf_byte_merge #(
  parameter int SW = 4,
  localparam int DW = SW * 8
) (
  input  logic [DW-1:0] old_data,
  input  logic [SW-1:0] old_strb,
  input  logic [DW-1:0] new_data,
  input  logic [SW-1:0] new_strb,
  output logic [DW-1:0] out_data,
  output logic [SW-1:0] out_strb
);
  for (genvar b = 0; b < SW; b++) begin : g_byte
    assign out_data[8*b +: 8] = new_strb[b] ? new_data[8*b +: 8] : old_data[8*b +: 8];
  end
  assign out_strb = old_strb | new_strb;
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_data,
  input  logic [DW/8-1:0] s_strb,
  input  logic [1:0]    s_type,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_data,
  output logic [DW/8-1:0] m_strb,
  output logic [1:0]    m_type,
  input  logic          bar_req,
  output logic          bar_ack
);
  localparam int SW  = DW / 8;
  localparam int OFS = $clog2(SW);
  localparam int WAW = AW - OFS;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic rst_i;
  wbuf_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_i));

  // entry storage, slot 0 oldest
  logic [WAW-1:0] wa_q  [DEPTH];
  logic [DW-1:0]  dat_q [DEPTH];
  logic [SW-1:0]  stb_q [DEPTH];
  logic [1:0]     typ_q [DEPTH];
  logic [WAW-1:0] wa_i  [DEPTH];
  logic [DW-1:0]  dat_i [DEPTH];
  logic [SW-1:0]  stb_i [DEPTH];
  logic [1:0]     typ_i [DEPTH];
  logic [WAW-1:0] wa_n  [DEPTH];
  logic [DW-1:0]  dat_n [DEPTH];
  logic [SW-1:0]  stb_n [DEPTH];
  logic [1:0]     typ_n [DEPTH];

  logic [CW-1:0]    count_q, count_n;
  logic             bar_pend_q, bar_pend_n;
  logic [DEPTH-1:0] vld, rel;
  logic [WAW-1:0]   s_wa;
  logic             mf_hit, can_merge, full, empty;
  logic [IW-1:0]    mf_idx;
  logic [DW-1:0]    bm_data;
  logic [SW-1:0]    bm_strb;
  logic             s_fire, pop, alloc, upd_en;

  assign s_wa = s_addr[AW-1:OFS];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld[i] = CW'(i) < count_q;
      rel[i] = is_relaxed(typ_q[i]);
    end
  end

  wbuf_merge_find #(.DEPTH(DEPTH), .WAW(WAW)) u_find (
    .vld(vld), .rel(rel), .wa(wa_q), .in_wa(s_wa), .hit(mf_hit), .idx(mf_idx)
  );

  wbuf_byte_merge #(.SW(SW)) u_merge (
    .old_data(dat_q[mf_idx]), .old_strb(stb_q[mf_idx]),
    .new_data(s_data), .new_strb(s_strb),
    .out_data(bm_data), .out_strb(bm_strb)
  );

  assign full      = count_q == CW'(DEPTH);
  assign empty     = count_q == '0;
  assign can_merge = mf_hit && is_relaxed(s_type);
  assign s_ready   = !bar_pend_q && (!full || can_merge);
  assign s_fire    = s_valid && s_ready;
  assign m_valid   = !empty;
  assign pop       = m_valid && m_ready;
  assign alloc     = s_fire && !can_merge;
  assign upd_en    = s_fire || pop;
  assign bar_ack   = bar_pend_q && empty;

  // insert stage: merge into the chosen slot or append at the tail
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      wa_i[i]  = wa_q[i];
      dat_i[i] = dat_q[i];
      stb_i[i] = stb_q[i];
      typ_i[i] = typ_q[i];
      if (s_fire && can_merge && (IW'(i) == mf_idx)) begin
        dat_i[i] = bm_data;
        stb_i[i] = bm_strb;
      end
      if (alloc && (CW'(i) == count_q)) begin
        wa_i[i]  = s_wa;
        dat_i[i] = s_data;
        stb_i[i] = s_strb;
        typ_i[i] = s_type;
      end
    end
  end

  // shift stage: drop the head when it is accepted
  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    if (g < DEPTH - 1) begin : g_mid
      assign wa_n[g]  = pop ? wa_i[g+1]  : wa_i[g];
      assign dat_n[g] = pop ? dat_i[g+1] : dat_i[g];
      assign stb_n[g] = pop ? stb_i[g+1] : stb_i[g];
      assign typ_n[g] = pop ? typ_i[g+1] : typ_i[g];
    end else begin : g_last
      assign wa_n[g]  = wa_i[g];
      assign dat_n[g] = dat_i[g];
      assign stb_n[g] = stb_i[g];
      assign typ_n[g] = typ_i[g];
    end
  end

  always_comb begin
    count_n    = count_q + CW'(alloc) - CW'(pop);
    bar_pend_n = bar_pend_q ? !empty : bar_req;
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        wa_q[i]  <= wa_n[i];
        dat_q[i] <= dat_n[i];
        stb_q[i] <= stb_n[i];
        typ_q[i] <= typ_n[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      count_q    <= '0;
      bar_pend_q <= 1'b0;
    end else begin
      count_q    <= count_n;
      bar_pend_q <= bar_pend_n;
    end
  end

  assign m_addr = {wa_q[0], {OFS{1'b0}}};
  assign m_data = dat_q[0];
  assign m_strb = stb_q[0];
  assign m_type = typ_q[0];

  a_r8_hold_presented: assert property (@(posedge clk) disable iff (!rst_i)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_data)
                           && $stable(m_strb) && $stable(m_type));

  a_r5_strict_allocates: assert property (@(posedge clk) disable iff (!rst_i)
    s_valid && s_ready && !is_relaxed(s_type) && !(m_valid && m_ready)
    |=> count_q == $past(count_q) + CW'(1));

  a_r9_full_stall: assert property (@(posedge clk) disable iff (!rst_i)
    (count_q == CW'(DEPTH)) && !is_relaxed(s_type) |-> !s_ready);

  a_r10_ack_empty: assert property (@(posedge clk) disable iff (!rst_i)
    bar_ack |-> !m_valid);

  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    bar_ack |=> !bar_ack);

  a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_i)
    bar_req && !bar_pend_q |=> !s_ready);
endmodule

// File: tb/wbuf_top_tb.sv
module wbuf_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_addr = '0;
  logic [31:0] s_data = '0;
  logic [3:0]  s_strb = '0;
  logic [1:0]  s_type = '0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [31:0] m_addr, m_data;
  logic [3:0]  m_strb;
  logic [1:0]  m_type;
  logic        bar_req = 1'b0;
  logic        bar_ack;

  int n_vec = 0;
  int n_err = 0;
  int wr_total = 0;
  logic [31:0] lg_addr [256];
  logic [31:0] lg_data [256];
  logic [3:0]  lg_strb [256];
  logic [1:0]  lg_type [256];

  always #10 clk = ~clk;

  wbuf_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_data(s_data),
    .s_strb(s_strb), .s_type(s_type),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data),
    .m_strb(m_strb), .m_type(m_type),
    .bar_req(bar_req), .bar_ack(bar_ack)
  );

  // write-port log: a write leaves at the posedge after a negedge with valid and ready
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      lg_addr[wr_total[7:0]] = m_addr;
      lg_data[wr_total[7:0]] = m_data;
      lg_strb[wr_total[7:0]] = m_strb;
      lg_type[wr_total[7:0]] = m_type;
      wr_total = wr_total + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bmask(input logic [3:0] s);
    return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
  endfunction

  task automatic chk_wr(input string tag, input int k, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] s, input logic [1:0] t);
    chk(tag, {32'h0, lg_addr[k[7:0]]}, {32'h0, a & 32'hFFFF_FFFC});
    chk(tag, {32'h0, lg_data[k[7:0]] & bmask(s)}, {32'h0, d & bmask(s)});
    chk(tag, {60'h0, lg_strb[k[7:0]]}, {60'h0, s});
    chk(tag, {62'h0, lg_type[k[7:0]]}, {62'h0, t});
  endtask

  // called and returns at posedge+2
  task automatic do_store(input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] s, input logic [1:0] t);
    s_valid = 1'b1; s_addr = a; s_data = d; s_strb = s; s_type = t;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    @(posedge clk); #2;
    s_valid = 1'b0;
  endtask

  task automatic drain();
    m_ready = 1'b1;
    @(negedge clk);
    while (m_valid) @(negedge clk);
    @(posedge clk); #2;
    m_ready = 1'b0;
  endtask

  function automatic logic [31:0] merged(input logic [31:0] o, input logic [31:0] n,
                                         input logic [3:0] ns);
    return (n & bmask(ns)) | (o & ~bmask(ns));
  endfunction

  initial begin
    int base;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    @(negedge clk);
    chk("R12 m_valid", {63'h0, m_valid}, 64'h0);
    chk("R12 bar_ack", {63'h0, bar_ack}, 64'h0);
    chk("R12 s_ready", {63'h0, s_ready}, 64'h1);
    @(posedge clk); #2;

    // sweep: filler at head, then A and B to one word, all type and strobe pairs
    for (int ta = 0; ta < 4; ta++) begin
      for (int tb = 0; tb < 4; tb++) begin
        for (int sa = 1; sa < 16; sa++) begin
          for (int sb = 1; sb < 16; sb++) begin
            automatic int cid = ((ta * 4 + tb) * 16 + sa) * 16 + sb;
            automatic logic [31:0] xa = 32'h4000 + 32'((cid % 64) * 16 + (cid % 4));
            automatic logic [31:0] da = 32'hA500_0000 | 32'(cid);
            automatic logic [31:0] db = ~da;
            automatic logic mrg = (ta == 0) && (tb == 0);
            base = wr_total;
            do_store(32'h100, 32'h1111_1111, 4'hF, 2'b00);
            do_store(xa, da, 4'(sa), 2'(ta));
            do_store(xa, db, 4'(sb), 2'(tb));
            drain();
            chk("R3 R5 write count", 64'(wr_total - base), mrg ? 64'd2 : 64'd3);
            chk_wr("R6 head order", base, 32'h100, 32'h1111_1111, 4'hF, 2'b00);
            if (mrg) begin
              chk_wr("R3 merged", base + 1, xa, merged(da, db, 4'(sb)), 4'(sa | sb), 2'b00);
            end else begin
              chk_wr("R1 R2 R5 first", base + 1, xa, da, 4'(sa), 2'(ta));
              chk_wr("R1 R2 R5 second", base + 2, xa, db, 4'(sb), 2'(tb));
            end
          end
        end
      end
    end

    // R4: head entry on the port is not merged into; R8 it stays stable
    base = wr_total;
    do_store(32'h200, 32'h0000_3344, 4'b0011, 2'b00);
    do_store(32'h200, 32'h5566_0000, 4'b1100, 2'b00);
    @(negedge clk);
    chk("R8 head data held", {32'h0, m_data & 32'h0000_FFFF}, 64'h3344);
    chk("R8 head strb held", {60'h0, m_strb}, 64'h3);
    @(posedge clk); #2;
    drain();
    chk("R4 no head merge count", 64'(wr_total - base), 64'd2);
    chk_wr("R4 second", base + 1, 32'h200, 32'h5566_0000, 4'b1100, 2'b00);

    // R7: younger device entry blocks the merge
    base = wr_total;
    do_store(32'h300, 32'h1, 4'hF, 2'b00);
    do_store(32'h304, 32'h0000_00AA, 4'b0001, 2'b00);
    do_store(32'h308, 32'hDEAD_BEEF, 4'hF, 2'b01);
    do_store(32'h304, 32'h0000_BB00, 4'b0010, 2'b00);
    drain();
    chk("R7 count", 64'(wr_total - base), 64'd4);
    chk_wr("R7 order 1", base + 1, 32'h304, 32'h0000_00AA, 4'b0001, 2'b00);
    chk_wr("R7 order 2", base + 2, 32'h308, 32'hDEAD_BEEF, 4'hF, 2'b01);
    chk_wr("R7 order 3", base + 3, 32'h304, 32'h0000_BB00, 4'b0010, 2'b00);

    // R6: merged store overtakes a younger relaxed entry
    base = wr_total;
    do_store(32'h400, 32'h7, 4'hF, 2'b00);
    do_store(32'h404, 32'h0000_0011, 4'b0001, 2'b00);
    do_store(32'h408, 32'h2222_2222, 4'hF, 2'b00);
    do_store(32'h404, 32'h0000_3300, 4'b0010, 2'b00);
    drain();
    chk("R6 count", 64'(wr_total - base), 64'd3);
    chk_wr("R6 merged first", base + 1, 32'h404, 32'h0000_3311, 4'b0011, 2'b00);
    chk_wr("R6 other after", base + 2, 32'h408, 32'h2222_2222, 4'hF, 2'b00);

    // R9: full buffer
    base = wr_total;
    do_store(32'h500, 32'h0, 4'hF, 2'b00);
    do_store(32'h504, 32'h0, 4'hF, 2'b00);
    do_store(32'h508, 32'h0, 4'hF, 2'b01);
    do_store(32'h50C, 32'h0000_0001, 4'b0001, 2'b00);
    s_valid = 1'b1; s_addr = 32'h50C; s_data = 32'h0; s_strb = 4'b0010; s_type = 2'b01;
    @(negedge clk);
    chk("R9 full device stall", {63'h0, s_ready}, 64'h0);
    @(posedge clk); #2;
    s_addr = 32'h504; s_type = 2'b00;
    @(negedge clk);
    chk("R9 full blocked merge stall", {63'h0, s_ready}, 64'h0);
    @(posedge clk); #2;
    s_valid = 1'b0;
    do_store(32'h50C, 32'h0000_0200, 4'b0010, 2'b00);
    drain();
    chk("R9 count", 64'(wr_total - base), 64'd4);
    chk_wr("R9 merged tail", base + 3, 32'h50C, 32'h0000_0201, 4'b0011, 2'b00);

    // R10 R11: barrier on empty buffer
    bar_req = 1'b1;
    @(negedge clk);
    chk("R10 no ack same cycle", {63'h0, bar_ack}, 64'h0);
    @(posedge clk); #2;
    bar_req = 1'b0;
    @(negedge clk);
    chk("R10 ack empty", {63'h0, bar_ack}, 64'h1);
    chk("R11 stall at ack", {63'h0, s_ready}, 64'h0);
    @(negedge clk);
    chk("R10 ack one cycle", {63'h0, bar_ack}, 64'h0);
    chk("R11 ready after ack", {63'h0, s_ready}, 64'h1);
    @(posedge clk); #2;

    // barrier with two held writes
    do_store(32'h600, 32'h1, 4'hF, 2'b01);
    do_store(32'h604, 32'h2, 4'hF, 2'b00);
    bar_req = 1'b1;
    @(posedge clk); #2;
    bar_req = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 no early ack", {63'h0, bar_ack}, 64'h0);
      chk("R11 stores held off", {63'h0, s_ready}, 64'h0);
    end
    @(posedge clk); #2;
    m_ready = 1'b1;
    @(negedge clk);
    chk("R10 pending 1", {63'h0, bar_ack}, 64'h0);
    @(negedge clk);
    chk("R10 pending 2", {63'h0, bar_ack}, 64'h0);
    @(negedge clk);
    chk("R10 ack after last", {63'h0, bar_ack}, 64'h1);
    chk("R10 empty at ack", {63'h0, m_valid}, 64'h0);
    @(negedge clk);
    chk("R10 ack pulse", {63'h0, bar_ack}, 64'h0);
    @(posedge clk); #2;
    m_ready = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec + 1, n_err + 1);
    $finish;
  end
endmodule